// File: doc/BRIEF.md
# SPI Master DMA Engine

This block moves a run of bytes between a local byte-wide RAM and an SPI master shifter with no processor involvement. Software loads a transmit start address, a receive start address and a byte count through a small register port, then writes the control register with the go bit set. The engine clocks out every byte fetched from the transmit side of the RAM. At the same time it shifts in one byte and stores it at the receive side, so each byte position is a full-duplex exchange.

The length register holds the number of bytes minus one, so the longest transfer is 1024 bytes. Each address can be told separately to step after every byte or to stay fixed. A fixed receive address suits a single data port. A fixed transmit address lets one fill byte be sent repeatedly. A 4-bit gap field adds idle clock cycles between bytes. While one byte is shifting, the next transmit byte is already read from RAM, so the gap field alone sets the spacing. When the last byte is stored, the go bit clears itself and the interrupt flag is raised. A mode bit decides whether the flag is raised only at that point or after every byte. Software must reprogram the addresses and the count before the next run.

Top module: `spi_dma_eng`

## Requirements
- R1: After reset every register reads 0x00, SCK and SDO are low, and no RAM read or write is issued.
- R2: Writing offset 0 with bit 0 set while idle starts a transfer. Busy reads as 1 in bit 1 of offset 7 and in bit 0 of offset 0 from the next cycle until the last byte is stored, and then drops by itself.
- R3: The count is 10 bits, with bits 7:0 at offset 5 and bits 9:8 at offset 6, bits 1:0. A transfer moves count+1 bytes (0x1FF moves 512), and the count reads zero once the transfer is done.
- R4: For each byte, the engine reads the RAM at the transmit address and shifts that byte out MSB first. It stores the byte received in the same eight bit slots at the receive address. A RAM read and a RAM write never occur in the same cycle.
- R5: The addresses are 12 bits each. Transmit uses offset 1 (bits 7:0) and offset 2 (bits 11:8). Receive uses offset 3 and offset 4 in the same layout. Control bit 1 makes the receive address step by one per byte, and control bit 2 does the same for the transmit address. Addresses wrap modulo 4096. After completion a stepping address reads start+count+1, and a fixed one reads its start value.
- R6: SCK runs at clk/4 and idles low. Each bit is two cycles low followed by two cycles high. SDO changes only while SCK is low, and SDI is taken at the rising SCK edge. Within a byte, rising SCK edges are 4 cycles apart.
- R7: Control bits 7:4 hold a gap G. From the last rising SCK edge of one byte to the first rising edge of the next, 4+G cycles pass.
- R8: Status bit 0 (offset 7) is the interrupt flag, also driven on `irq`. It is set when the last byte is stored. With control bit 3 at 1 it is set only then; with bit 3 at 0 it is also set after every earlier byte. Writing offset 7 with bit 0 set clears it.
- R9: While busy, writes to offsets 0 to 6 have no effect on the transfer or on the register contents.
- R10: Registers read back what was written, with unused high bits reading 0. Control reads as {gap, once, tx step, rx step, busy}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for both read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Interrupt flag |
| ram_re | output | 1 | RAM read strobe; data is returned on ram_rdata in the following cycle |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 12 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| sck | output | 1 | SPI clock, idles low |
| sdo | output | 1 | SPI data out |
| sdi | input | 1 | SPI data in |

## Verification
Busy becomes visible one cycle after the clock edge that takes the go write. The bench's write task returns at the following falling edge and reads status there. Status is then polled every cycle to see whether the flag appears while busy is still high. The model slave records SDO at each rising SCK edge and changes SDI on each falling edge, so it exercises the mid-bit sampling point. SCK rising edges are timed in nanoseconds against 16 ns within a byte and 16+4G ns across a byte boundary. Register and RAM contents are compared only after busy has dropped, when the last write has landed.

// File: rtl/spi_dma_pkg.sv
`timescale 1ns/1ps
package spi_dma_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE, SQ_FETCH, SQ_PRIME, SQ_SHIFT, SQ_GAP
  } seq_t;

  localparam logic [2:0] RG_CTRL = 3'd0;
  localparam logic [2:0] RG_TXL  = 3'd1;
  localparam logic [2:0] RG_TXH  = 3'd2;
  localparam logic [2:0] RG_RXL  = 3'd3;
  localparam logic [2:0] RG_RXH  = 3'd4;
  localparam logic [2:0] RG_CNL  = 3'd5;
  localparam logic [2:0] RG_CNH  = 3'd6;
  localparam logic [2:0] RG_STAT = 3'd7;
endpackage

// File: rtl/spi_dma_regs.sv
`timescale 1ns/1ps
module spi_dma_regs
  import spi_dma_pkg::*;
#(
  parameter int AW = 12,
  parameter int CW = 10,
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          busy,
  input  logic          tx_step,
  input  logic          rx_step,
  input  logic          cnt_step,
  input  logic          flag_set,
  output logic          start,
  output logic [AW-1:0] txa,
  output logic [AW-1:0] rxa,
  output logic [CW-1:0] cnt,
  output logic          rx_inc,
  output logic          tx_inc,
  output logic          once,
  output logic [GW-1:0] gap,
  output logic          flag
);
  localparam int AHW = AW - 8;
  localparam int CHW = CW - 8;

  logic [AW-1:0] txa_q, txa_d, rxa_q, rxa_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [GW-1:0] gap_q, gap_d;
  logic          rinc_q, rinc_d, tinc_q, tinc_d, once_q, once_d;
  logic          flag_q, flag_d;
  logic          cfg_we;
  logic [7:0]    ctrl_rd;

  assign cfg_we = wr_en && !busy;
  assign start  = cfg_we && (addr == RG_CTRL) && wdata[0];

  always_comb begin
    txa_d  = txa_q;
    rxa_d  = rxa_q;
    cnt_d  = cnt_q;
    gap_d  = gap_q;
    rinc_d = rinc_q;
    tinc_d = tinc_q;
    once_d = once_q;
    flag_d = flag_q;
    if (cfg_we) begin
      unique case (addr)
        RG_CTRL: begin
          rinc_d = wdata[1];
          tinc_d = wdata[2];
          once_d = wdata[3];
          gap_d  = wdata[4 +: GW];
        end
        RG_TXL:  txa_d[7:0]    = wdata;
        RG_TXH:  txa_d[AW-1:8] = wdata[AHW-1:0];
        RG_RXL:  rxa_d[7:0]    = wdata;
        RG_RXH:  rxa_d[AW-1:8] = wdata[AHW-1:0];
        RG_CNL:  cnt_d[7:0]    = wdata;
        RG_CNH:  cnt_d[CW-1:8] = wdata[CHW-1:0];
        default: ;
      endcase
    end
    if (tx_step && tinc_q) txa_d = txa_q + AW'(1);
    if (rx_step && rinc_q) rxa_d = rxa_q + AW'(1);
    if (cnt_step)          cnt_d = cnt_q - CW'(1);
    if (wr_en && (addr == RG_STAT) && wdata[0]) flag_d = 1'b0;
    if (flag_set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txa_q  <= '0;
      rxa_q  <= '0;
      cnt_q  <= '0;
      gap_q  <= '0;
      rinc_q <= 1'b0;
      tinc_q <= 1'b0;
      once_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      txa_q  <= txa_d;
      rxa_q  <= rxa_d;
      cnt_q  <= cnt_d;
      gap_q  <= gap_d;
      rinc_q <= rinc_d;
      tinc_q <= tinc_d;
      once_q <= once_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[0]        = busy;
    ctrl_rd[1]        = rinc_q;
    ctrl_rd[2]        = tinc_q;
    ctrl_rd[3]        = once_q;
    ctrl_rd[4 +: GW]  = gap_q;
  end

  always_comb begin
    unique case (addr)
      RG_CTRL: rdata = ctrl_rd;
      RG_TXL:  rdata = txa_q[7:0];
      RG_TXH:  rdata = 8'(txa_q[AW-1:8]);
      RG_RXL:  rdata = rxa_q[7:0];
      RG_RXH:  rdata = 8'(rxa_q[AW-1:8]);
      RG_CNL:  rdata = cnt_q[7:0];
      RG_CNH:  rdata = 8'(cnt_q[CW-1:8]);
      default: rdata = {6'b0, busy, flag_q};
    endcase
  end

  assign txa    = txa_q;
  assign rxa    = rxa_q;
  assign cnt    = cnt_q;
  assign rx_inc = rinc_q;
  assign tx_inc = tinc_q;
  assign once   = once_q;
  assign gap    = gap_q;
  assign flag   = flag_q;

  // R9
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr == RG_CNL) |=>
      (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CW'(1)))
    else $error("count changed by a write while busy");

  // R9
  hold_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr == RG_CTRL) |=> ($stable(gap_q) && $stable(once_q)))
    else $error("control changed by a write while busy");
endmodule

// File: rtl/spi_dma_shift.sv
`timescale 1ns/1ps
module spi_dma_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          sdi,
  output logic          sck,
  output logic          sdo,
  output logic          fetch_slot,
  output logic          byte_end,
  output logic [DW-1:0] rx_byte
);
  localparam int BW = $clog2(DW);

  logic          act_q, act_d;
  logic [1:0]    ph_q, ph_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [DW-1:0] tsr_q, tsr_d, rsr_q, rsr_d;

  assign byte_end   = act_q && (ph_q == 2'd3) && (bit_q == BW'(DW - 1));
  assign fetch_slot = act_q && (ph_q == 2'd0) && (bit_q == '0);

  always_comb begin
    act_d = act_q;
    ph_d  = ph_q;
    bit_d = bit_q;
    tsr_d = tsr_q;
    rsr_d = rsr_q;
    if (act_q) begin
      ph_d = ph_q + 2'd1;
      if (ph_q == 2'd1) rsr_d = {rsr_q[DW-2:0], sdi};
      if (ph_q == 2'd3) begin
        tsr_d = {tsr_q[DW-2:0], 1'b0};
        bit_d = bit_q + BW'(1);
      end
      if (byte_end) act_d = 1'b0;
    end
    if (load) begin
      act_d = 1'b1;
      ph_d  = 2'd0;
      bit_d = '0;
      tsr_d = load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      ph_q  <= '0;
      bit_q <= '0;
      tsr_q <= '0;
      rsr_q <= '0;
    end else begin
      act_q <= act_d;
      ph_q  <= ph_d;
      bit_q <= bit_d;
      tsr_q <= tsr_d;
      rsr_q <= rsr_d;
    end
  end

  assign sck     = act_q & ph_q[1];
  assign sdo     = act_q & tsr_q[DW-1];
  assign rx_byte = rsr_q;

  // R6
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(sdo))
    else $error("SDO moved at the rising SCK edge");
endmodule

// File: rtl/spi_dma_eng.sv
`timescale 1ns/1ps
module spi_dma_eng
  import spi_dma_pkg::*;
#(
  parameter int AW = 12,
  parameter int CW = 10,
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          irq,
  output logic          ram_re,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [7:0]    ram_wdata,
  input  logic [7:0]    ram_rdata,
  output logic          sck,
  output logic          sdo,
  input  logic          sdi
);
  localparam int DW = 8;

  logic [1:0]    rs_q;
  logic          rst_sn;
  seq_t          st_q, st_d;
  logic [GW-1:0] gc_q, gc_d;
  logic [DW-1:0] nb_q, nb_d, ld_data, rx_byte;
  logic          pend_q, pend_d;
  logic          busy, start, ld, fetch_slot, byte_end;
  logic          tx_step, rx_step, cnt_step, flag_set;
  logic [AW-1:0] txa, rxa;
  logic [CW-1:0] cnt;
  logic          rx_inc, tx_inc, once;
  logic [GW-1:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sn = rs_q[1];

  assign busy = (st_q != SQ_IDLE);

  spi_dma_regs #(.AW(AW), .CW(CW), .GW(GW)) u_regs (
    .clk(clk), .rst_n(rst_sn), .wr_en(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy),
    .tx_step(tx_step), .rx_step(rx_step), .cnt_step(cnt_step),
    .flag_set(flag_set), .start(start), .txa(txa), .rxa(rxa), .cnt(cnt),
    .rx_inc(rx_inc), .tx_inc(tx_inc), .once(once), .gap(gap), .flag(irq)
  );

  spi_dma_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_sn), .load(ld), .load_data(ld_data), .sdi(sdi),
    .sck(sck), .sdo(sdo), .fetch_slot(fetch_slot), .byte_end(byte_end),
    .rx_byte(rx_byte)
  );

  always_comb begin
    st_d     = st_q;
    gc_d     = gc_q;
    nb_d     = nb_q;
    pend_d   = 1'b0;
    ram_re   = 1'b0;
    ram_we   = 1'b0;
    tx_step  = 1'b0;
    rx_step  = 1'b0;
    cnt_step = 1'b0;
    flag_set = 1'b0;
    ld       = 1'b0;
    ld_data  = nb_q;
    if (pend_q) nb_d = ram_rdata;
    unique case (st_q)
      SQ_IDLE:  if (start) st_d = SQ_FETCH;
      SQ_FETCH: begin
        ram_re  = 1'b1;
        tx_step = 1'b1;
        st_d    = SQ_PRIME;
      end
      SQ_PRIME: begin
        ld      = 1'b1;
        ld_data = ram_rdata;
        st_d    = SQ_SHIFT;
      end
      SQ_SHIFT: begin
        if (fetch_slot && cnt != '0) begin
          ram_re  = 1'b1;
          tx_step = 1'b1;
          pend_d  = 1'b1;
        end
        if (byte_end) begin
          ram_we  = 1'b1;
          rx_step = 1'b1;
          if (cnt == '0) begin
            flag_set = 1'b1;
            st_d     = SQ_IDLE;
          end else begin
            cnt_step = 1'b1;
            flag_set = !once;
            if (gap == '0) ld = 1'b1;
            else begin
              gc_d = gap - GW'(1);
              st_d = SQ_GAP;
            end
          end
        end
      end
      SQ_GAP: begin
        if (gc_q == '0) begin
          ld   = 1'b1;
          st_d = SQ_SHIFT;
        end else gc_d = gc_q - GW'(1);
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= SQ_IDLE;
      gc_q   <= '0;
      nb_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      gc_q   <= gc_d;
      nb_q   <= nb_d;
      pend_q <= pend_d;
    end
  end

  assign ram_addr  = ram_we ? rxa : txa;
  assign ram_wdata = rx_byte;

  // R4
  ram_excl_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !(ram_re && ram_we))
    else $error("RAM read and write in one cycle");

  // R8
  end_flag_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(busy) |-> irq)
    else $error("transfer ended without raising the flag");

  // R8
  once_only_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (once && $rose(irq)) |-> !busy)
    else $error("flag raised mid-transfer in end-only mode");
endmodule

// File: tb/spi_dma_eng_bench.sv
`timescale 1ns/1ps
module spi_dma_eng_bench;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          reg_we;
  logic [2:0]    reg_addr;
  logic [7:0]    reg_wdata, reg_rdata;
  logic          irq, ram_re, ram_we;
  logic [AW-1:0] ram_addr;
  logic [7:0]    ram_wdata;
  logic [7:0]    ram_rdata;
  logic          sck, sdo, sdi;

  spi_dma_eng u_spi_dma_eng (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .sck(sck), .sdo(sdo), .sdi(sdi)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] seed = 8'h00;
  logic [7:0] wmem [4096];

  function automatic logic [7:0] t_pat(logic [11:0] a, logic [7:0] s);
    return a[7:0] ^ {a[11:8], 4'h0} ^ (s * 8'h35);
  endfunction

  function automatic logic [7:0] s_pat(int k, logic [7:0] s);
    logic [7:0] kk;
    kk = k[7:0];
    return kk * 8'd29 + s * 8'h11 + 8'h5A;
  endfunction

  function automatic logic s_bit(int n, logic [7:0] s);
    logic [7:0] b;
    b = s_pat(n >>> 3, s);
    return b[3'd7 - n[2:0]];
  endfunction

  // RAM model: reads return a pattern of the address, writes land in wmem
  always @(posedge clk) begin
    if (ram_re) ram_rdata <= t_pat(ram_addr, seed);
    if (ram_we) wmem[ram_addr] <= ram_wdata;
  end

  // slave model: SDI moves on falling SCK
  int fb = 0;
  int fb_base = 0;
  always @(negedge sck) fb = fb + 1;
  assign sdi = s_bit(fb - fb_base, seed);

  int rb = 0;
  int rb_base = 0;
  logic [7:0] acc = 8'h00;
  logic [7:0] cap [512];
  int test_id = 0;
  int last_id = -1;
  realtime last_t = 0.0;
  int exp_gap = 0;
  int gap_err = 0;
  int bit_err = 0;

  always @(posedge sck) begin : mon
    int k;
    realtime d;
    k = rb - rb_base;
    d = $realtime - last_t;
    if (test_id == last_id && k > 0) begin
      if (k % 8 == 0) begin
        if (d != real'(16 + 4 * exp_gap)) gap_err = gap_err + 1;
      end else if (d != 16.0) bit_err = bit_err + 1;
    end
    last_id = test_id;
    last_t  = $realtime;
    acc = {acc[6:0], sdo};
    if (k % 8 == 7) cap[(k / 8) % 512] = acc;
    rb = rb + 1;
  end

  typedef struct packed {
    logic [11:0] tx;
    logic [11:0] rx;
    logic [9:0]  cnt;
    logic [3:0]  gap;
    logic        rinc;
    logic        tinc;
    logic        once;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{12'h100, 12'h200, 10'd3, 4'd0,  1'b1, 1'b1, 1'b1},
    '{12'h300, 12'h400, 10'd0, 4'd5,  1'b1, 1'b1, 1'b1},
    '{12'h500, 12'h600, 10'd5, 4'd15, 1'b0, 1'b1, 1'b0},
    '{12'h700, 12'h800, 10'd4, 4'd2,  1'b1, 1'b0, 1'b1},
    '{12'hFFE, 12'hFFD, 10'd3, 4'd1,  1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run(input vec_t v, input int id, input bit inject);
    logic [7:0]  r, lo, hi;
    logic [11:0] ea;
    logic [7:0]  ex;
    int n, g0, b0, rb_end;
    bit saw;
    test_id = id;
    seed    = 8'(id * 13 + 1);
    exp_gap = int'(v.gap);
    rb_base = rb;
    fb_base = fb;
    g0 = gap_err;
    b0 = bit_err;
    n  = int'(v.cnt) + 1;
    wr(3'd1, v.tx[7:0]);
    wr(3'd2, {4'h0, v.tx[11:8]});
    wr(3'd3, v.rx[7:0]);
    wr(3'd4, {4'h0, v.rx[11:8]});
    wr(3'd5, v.cnt[7:0]);
    wr(3'd6, {6'h0, v.cnt[9:8]});
    wr(3'd0, {v.gap, v.once, v.tinc, v.rinc, 1'b1});
    rd(3'd7, r);
    chk(r == 8'h02, "R2 busy set, flag clear after go", int'(r), 2);
    if (inject) begin
      repeat (10) @(negedge clk);
      wr(3'd1, 8'hAA);
      wr(3'd5, 8'h00);
      wr(3'd4, 8'h0F);
      wr(3'd0, 8'h01);
    end
    saw = 1'b0;
    for (int c = 0; c < 40000; c++) begin
      rd(3'd7, r);
      if (r[1] && r[0]) saw = 1'b1;
      if (!r[1]) break;
    end
    chk(r == 8'h01, "R8 flag set and R2 busy cleared at end", int'(r), 1);
    chk(irq, "R8 irq pin at end", int'(irq), 1);
    if (n > 1) chk(saw == !v.once, "R8 per-byte flag follows once bit", int'(saw), int'(!v.once));
    chk(rb - rb_base == 8 * n, "R3 bytes moved", (rb - rb_base) / 8, n);
    for (int k = 0; k < n; k++) begin
      ex = t_pat(v.tinc ? v.tx + 12'(k) : v.tx, seed);
      chk(cap[k % 512] == ex, "R4 byte shifted out MSB first", int'(cap[k % 512]), int'(ex));
    end
    if (v.rinc) begin
      for (int k = 0; k < n; k++) begin
        ex = s_pat(k, seed);
        chk(wmem[v.rx + 12'(k)] == ex, "R4 received byte stored", int'(wmem[v.rx + 12'(k)]), int'(ex));
      end
    end else begin
      ex = s_pat(n - 1, seed);
      chk(wmem[v.rx] == ex, "R5 fixed rx address holds last byte", int'(wmem[v.rx]), int'(ex));
    end
    rd(3'd1, lo); rd(3'd2, hi);
    ea = v.tinc ? v.tx + 12'(n) : v.tx;
    chk({hi[3:0], lo} == ea && hi[7:4] == 4'h0, "R5 final tx address", int'({hi, lo}), int'(ea));
    rd(3'd3, lo); rd(3'd4, hi);
    ea = v.rinc ? v.rx + 12'(n) : v.rx;
    chk({hi[3:0], lo} == ea && hi[7:4] == 4'h0, "R5 final rx address", int'({hi, lo}), int'(ea));
    rd(3'd5, lo); rd(3'd6, hi);
    chk(lo == 8'h00 && hi == 8'h00, "R3 count reads zero after run", int'({hi, lo}), 0);
    rd(3'd0, r);
    ex = {v.gap, v.once, v.tinc, v.rinc, 1'b0};
    chk(r == ex, "R10 control readback with R2 go cleared", int'(r), int'(ex));
    chk(gap_err == g0, "R7 inter-byte spacing 4+G cycles", gap_err - g0, 0);
    chk(bit_err == b0, "R6 bit spacing 4 cycles", bit_err - b0, 0);
    if (inject) begin
      rb_end = rb;
      repeat (50) @(negedge clk);
      chk(rb == rb_end && !ram_re, "R9 go write while busy did not restart", rb - rb_end, 0);
    end
    wr(3'd7, 8'h01);
    rd(3'd7, r);
    chk(r == 8'h00 && !irq, "R8 flag cleared by status write", int'(r), 0);
  endtask

  task automatic run_all();
    logic [7:0] r;
    reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!sck && !sdo && !ram_re && !ram_we, "R1 pins idle in reset",
        int'({sck, sdo, ram_re, ram_we}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), r);
      chk(r == 8'h00, "R1 register reads zero after reset", int'(r), 0);
    end
    chk(!sck && !sdo && !irq, "R1 outputs low after reset", int'({sck, sdo, irq}), 0);

    wr(3'd1, 8'h5C); rd(3'd1, r);
    chk(r == 8'h5C, "R10 tx low readback", int'(r), 8'h5C);
    wr(3'd2, 8'hF7); rd(3'd2, r);
    chk(r == 8'h07, "R10 tx high masked to 4 bits", int'(r), 8'h07);
    wr(3'd6, 8'hFF); rd(3'd6, r);
    chk(r == 8'h03, "R10 count high masked to 2 bits", int'(r), 8'h03);
    wr(3'd0, 8'hA6); rd(3'd0, r);
    chk(r == 8'hA6, "R10 control readback without go", int'(r), 8'hA6);

    for (int i = 0; i < 5; i++) run(VECS[i], i + 1, 1'b0);

    // R9: writes during a transfer are dropped
    run('{12'h040, 12'h0C0, 10'd7, 4'd3, 1'b1, 1'b1, 1'b1}, 10, 1'b1);
    // R3: longest common case, 0x1FF moves 512 bytes
    run('{12'h200, 12'h000, 10'h1FF, 4'd0, 1'b1, 1'b1, 1'b1}, 11, 1'b0);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog R2 transfer never ended act=%0h exp=%0h", 1, 0);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule